// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a 9-bit wide, 256-word FIFO. Its write port and its read port run on independent clocks. Four active-low status flags report the fill level. Two of them, full and almost-full, are registered on the write clock. The other two, empty and almost-empty, are registered on the read clock. The write and read pointers cross between the clock domains as Gray code through two-flop synchronizers. Each flag therefore asserts exactly, and releases a few cycles late, which is the safe direction.

One multipurpose input, `wrEn2Ld`, is sampled while reset is held, and it picks one of two modes:

- **Dual-enable mode** (pin high during reset): the pin becomes a second write enable.
- **Offset-load mode** (pin low during reset): the pin becomes a load strobe. While it is low, write-clock edges store the two threshold offsets from the data input, and read-clock edges show them on the data output.

The almost-empty and almost-full thresholds both start at 7 words. A read needs both read enables low. Read data appears one read-clock cycle after the accepting edge, qualified by `rdValid`. Both clocks must be running while reset is asserted so that the mode can be captured.

Top module: `dcfifo_top`

## Requirements
- R1: While `rstN` is low and after it rises, `fullN` and `almostFullN` are 1, `emptyN` and `almostEmptyN` are 0, and `rdValid` is 0.
- R2: In dual-enable mode (`wrEn2Ld` = 1 during reset), a word is stored only when `wrEn1N` = 0 and `wrEn2Ld` = 1 at a write-clock edge. With `wrEn2Ld` = 0 nothing is stored, and neither threshold changes.
- R3: In offset-load mode (`wrEn2Ld` = 0 during reset), `wrEn1N` = 0 with `wrEn2Ld` = 1 stores a data word.
- R4: A read happens only when `rdEn1N` = 0 and `rdEn2N` = 0 at a read-clock edge. The oldest word appears on `rdData`, with `rdValid` = 1, in the following read-clock cycle. Words leave in write order.
- R5: A write attempted while `fullN` = 0 is dropped and stores nothing.
- R6: A read attempted while `emptyN` = 0 produces no `rdValid` and leaves the contents unchanged.
- R7: Once settled, `almostEmptyN` = 0 exactly when occupancy ≤ the almost-empty offset. After reset that offset is 7.
- R8: Once settled, `almostFullN` = 0 exactly when free space (256 − occupancy) ≤ the almost-full offset. After reset that offset is 7.
- R9: In offset-load mode, each write-clock edge with `wrEn2Ld` = 0 and `wrEn1N` = 0 stores `wrData[7:0]` into an offset. The target alternates: almost-empty first, then almost-full, then back to almost-empty.
- R10: In offset-load mode, each read-clock edge with `wrEn2Ld` = 0 and both read enables low puts an offset on `rdData` (zero-extended), with `rdValid` = 1, in the next cycle. The sequence alternates almost-empty, almost-full, and so on. No data word is consumed.
- R11: `fullN` falls in the write-clock cycle right after the edge that stores the 256th word. `emptyN` falls in the read-clock cycle right after the edge that removes the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrData | input | 9 | Write data; bits 7:0 carry an offset in load mode |
| wrEn1N | input | 1 | Primary write enable, active low |
| wrEn2Ld | input | 1 | Mode-selected second write enable or offset load strobe |
| rdEn1N | input | 1 | Read enable 1, active low |
| rdEn2N | input | 1 | Read enable 2, active low |
| rdData | output | 9 | Read data or offset readback |
| rdValid | output | 1 | `rdData` carries a new word this cycle |
| fullN | output | 1 | Full flag, active low, write-clock domain |
| almostFullN | output | 1 | Almost-full flag, active low, write-clock domain |
| emptyN | output | 1 | Empty flag, active low, read-clock domain |
| almostEmptyN | output | 1 | Almost-empty flag, active low, read-clock domain |

## Verification
The bench targets the edge of each threshold, testing both occupancies 7/8 and free space 7/8. A design that is off by one in the comparison would flip a flag one word early or late.

It pushes writes into a full FIFO and reads from an empty one. A missing guard would wrap a pointer, which shows up as corrupted or extra data when the FIFO is drained.

It checks the cycle in which full and empty fall. A design that took these flags from the synchronized pointer would raise them late and let a write or read slip through.

In offset-load mode it writes three offsets and reads three back, then drains the data that was stored beforehand. A wrong wrap order or a pointer that moved during readback would show as a wrong value or lost data.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  // Strobes issued by the control unit towards the datapath.
  typedef struct packed {
    logic memWe;   // store wrData into the array (write domain)
    logic offWe;   // store wrData into an offset register (write domain)
    logic offSel;  // 0: almost-empty offset, 1: almost-full offset
    logic rdAdv;   // fetch the word at rdAddr (read domain)
    logic rbShow;  // present an offset on rdData (read domain)
    logic rbSel;   // 0: almost-empty offset, 1: almost-full offset
  } fifoStb_t;

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/dcfifo_ctrl.sv
module dcfifo_ctrl
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 8
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn1N,
  input  logic              wrEn2Ld,
  input  logic              rdEn1N,
  input  logic              rdEn2N,
  input  logic [OFF_W-1:0]  aeOff,
  input  logic [OFF_W-1:0]  afOff,
  output fifoStb_t          stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              fullN,
  output logic              almostFullN,
  output logic              emptyN,
  output logic              almostEmptyN
);

  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CMP_W = ((OFF_W > PTR_W) ? OFF_W : PTR_W) + 1;

  function automatic logic [PTR_W-1:0] bin2gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [CMP_W-1:0] clampOff(input logic [OFF_W-1:0] off);
    if (CMP_W'(off) > CMP_W'(DEPTH)) return CMP_W'(DEPTH);
    return CMP_W'(off);
  endfunction

  // ---------------- mode capture (sampled while reset is held) ----------
  logic wrModeLoad, rdModeLoad;

  always_ff @(posedge wrClk) begin
    if (!rstN) wrModeLoad <= ~wrEn2Ld;
  end

  always_ff @(posedge rdClk) begin
    if (!rstN) rdModeLoad <= ~wrEn2Ld;
  end

  // ---------------- write domain ----------------------------------------
  logic [PTR_W-1:0] wrBin, wrGray, wrBinNext;
  logic [PTR_W-1:0] rdGraySyncW, rdBinSyncW, usedNext;
  logic [CMP_W-1:0] freeNext;
  logic             memWe, offWe, offSel;

  assign memWe     = !wrEn1N && wrEn2Ld && fullN;
  assign offWe     = wrModeLoad && !wrEn1N && !wrEn2Ld;
  assign wrBinNext = wrBin + PTR_W'(memWe);
  assign rdBinSyncW = gray2bin(rdGraySyncW);
  assign usedNext  = wrBinNext - rdBinSyncW;
  assign freeNext  = CMP_W'(DEPTH) - CMP_W'(usedNext);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin       <= '0;
      wrGray      <= '0;
      fullN       <= 1'b1;
      almostFullN <= 1'b1;
      offSel      <= 1'b0;
    end else begin
      wrBin       <= wrBinNext;
      wrGray      <= bin2gray(wrBinNext);
      fullN       <= (usedNext != PTR_W'(DEPTH));
      almostFullN <= (freeNext > clampOff(afOff));
      offSel      <= offSel ^ offWe;
    end
  end

  // ---------------- read domain -----------------------------------------
  logic [PTR_W-1:0] rdBin, rdGray, rdBinNext;
  logic [PTR_W-1:0] wrGraySyncR, wrBinSyncR, fillNext;
  logic             rdReq, rbActive, rdAdv, rbShow, rbSel;

  assign rdReq      = !rdEn1N && !rdEn2N;
  assign rbActive   = rdModeLoad && !wrEn2Ld;
  assign rbShow     = rdReq && rbActive;
  assign rdAdv      = rdReq && !rbActive && emptyN;
  assign rdBinNext  = rdBin + PTR_W'(rdAdv);
  assign wrBinSyncR = gray2bin(wrGraySyncR);
  assign fillNext   = wrBinSyncR - rdBinNext;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin        <= '0;
      rdGray       <= '0;
      emptyN       <= 1'b0;
      almostEmptyN <= 1'b0;
      rbSel        <= 1'b0;
    end else begin
      rdBin        <= rdBinNext;
      rdGray       <= bin2gray(rdBinNext);
      emptyN       <= (fillNext != '0);
      almostEmptyN <= (CMP_W'(fillNext) > clampOff(aeOff));
      rbSel        <= rbSel ^ rbShow;
    end
  end

  // ---------------- pointer crossing ------------------------------------
  dcfifo_sync #(.W(PTR_W)) wr2rd_i (
    .clk (rdClk), .rstN(rstN), .d(wrGray), .q(wrGraySyncR)
  );

  dcfifo_sync #(.W(PTR_W)) rd2wr_i (
    .clk (wrClk), .rstN(rstN), .d(rdGray), .q(rdGraySyncW)
  );

  // ---------------- outputs to datapath ---------------------------------
  assign wrAddr = wrBin[ADDR_W-1:0];
  assign rdAddr = rdBin[ADDR_W-1:0];

  always_comb begin
    stb.memWe  = memWe;
    stb.offWe  = offWe;
    stb.offSel = offSel;
    stb.rdAdv  = rdAdv;
    stb.rbShow = rbShow;
    stb.rbSel  = rbSel;
  end

endmodule

// File: rtl/dcfifo_dpath.sv
module dcfifo_dpath
  import dcfifo_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int ADDR_W  = 8,
  parameter int OFF_W   = 8,
  parameter int DEF_OFF = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStb_t          stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [OFF_W-1:0]  aeOff,
  output logic [OFF_W-1:0]  afOff,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [OFF_W-1:0]  rbOff;

  always_ff @(posedge wrClk) begin
    if (stb.memWe) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      aeOff <= OFF_W'(DEF_OFF);
      afOff <= OFF_W'(DEF_OFF);
    end else if (stb.offWe) begin
      if (stb.offSel) afOff <= wrData[OFF_W-1:0];
      else            aeOff <= wrData[OFF_W-1:0];
    end
  end

  assign rbOff = stb.rbSel ? afOff : aeOff;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.rdAdv | stb.rbShow;
      if (stb.rdAdv)       rdData <= mem[rdAddr];
      else if (stb.rbShow) rdData <= DATA_W'(rbOff);
    end
  end

endmodule

// File: rtl/dcfifo_top.sv
module dcfifo_top
  import dcfifo_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int ADDR_W  = 8,
  parameter int OFF_W   = 8,
  parameter int DEF_OFF = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn1N,
  input  logic              wrEn2Ld,
  input  logic              rdEn1N,
  input  logic              rdEn2N,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              fullN,
  output logic              almostFullN,
  output logic              emptyN,
  output logic              almostEmptyN
);

  fifoStb_t          stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [OFF_W-1:0]  aeOff, afOff;

  dcfifo_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn1N(wrEn1N), .wrEn2Ld(wrEn2Ld), .rdEn1N(rdEn1N), .rdEn2N(rdEn2N),
    .aeOff(aeOff), .afOff(afOff),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullN(fullN), .almostFullN(almostFullN),
    .emptyN(emptyN), .almostEmptyN(almostEmptyN)
  );

  dcfifo_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W),
                 .DEF_OFF(DEF_OFF)) dpath_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData),
    .aeOff(aeOff), .afOff(afOff),
    .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/dcfifo_chk.sv
module dcfifo_chk (
  input logic wrClk,
  input logic rdClk,
  input logic rstN,
  input logic wrEn1N,
  input logic wrEn2Ld,
  input logic rdEn1N,
  input logic rdEn2N,
  input logic rdValid,
  input logic fullN,
  input logic almostFullN,
  input logic emptyN,
  input logic almostEmptyN
);

  AST_FULL_IMPLIES_AFULL: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |-> !almostFullN); // R8

  AST_EMPTY_IMPLIES_AEMPTY: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |-> !almostEmptyN); // R7

  AST_VALID_NEEDS_BOTH_EN: assert property (@(posedge rdClk) disable iff (!rstN)
    rdValid |-> $past(!rdEn1N && !rdEn2N)); // R4

  AST_NO_READ_WHEN_EMPTY: assert property (@(posedge rdClk) disable iff (!rstN)
    $past(!emptyN && wrEn2Ld) |-> !rdValid); // R6

  AST_FULL_ONLY_AFTER_WRITE: assert property (@(posedge wrClk) disable iff (!rstN)
    $fell(fullN) |-> $past(!wrEn1N && wrEn2Ld)); // R11

  AST_EMPTY_ONLY_AFTER_READ: assert property (@(posedge rdClk) disable iff (!rstN)
    $fell(emptyN) |-> $past(!rdEn1N && !rdEn2N)); // R11

endmodule

bind dcfifo_top dcfifo_chk chk_i (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
  .wrEn1N(wrEn1N), .wrEn2Ld(wrEn2Ld), .rdEn1N(rdEn1N), .rdEn2N(rdEn2N),
  .rdValid(rdValid), .fullN(fullN), .almostFullN(almostFullN),
  .emptyN(emptyN), .almostEmptyN(almostEmptyN)
);

// File: tb/dcfifo_top_tb_top.sv
module dcfifo_top_tb_top;

  localparam int DEPTH = 256;

  logic       wrClk, rdClk, rstN;
  logic [8:0] wrData;
  logic       wrEn1N, wrEn2Ld, rdEn1N, rdEn2N;
  logic [8:0] rdData;
  logic       rdValid, fullN, almostFullN, emptyN, almostEmptyN;

  int         nTests, nFails;
  logic [8:0] model[$];
  int         aeExp, afExp;
  bit         rbMode, modeLoad;

  dcfifo_top dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrData(wrData),
    .wrEn1N(wrEn1N), .wrEn2Ld(wrEn2Ld), .rdEn1N(rdEn1N), .rdEn2N(rdEn2N),
    .rdData(rdData), .rdValid(rdValid), .fullN(fullN),
    .almostFullN(almostFullN), .emptyN(emptyN), .almostEmptyN(almostEmptyN)
  );

  initial begin wrClk = 0; forever #2 wrClk = ~wrClk; end
  initial begin rdClk = 0; #1; forever #3 rdClk = ~rdClk; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expAeN(input int n); return (n > aeExp) ? 1 : 0; endfunction
  function automatic int expAfN(input int n); return ((DEPTH - n) > afExp) ? 1 : 0; endfunction

  // read-data scoreboard
  always @(negedge rdClk) begin
    if (rstN && rdValid && !rbMode) begin
      if (model.size() == 0) chk(0, "R6 read data with nothing stored", int'(rdData), -1);
      else begin
        logic [8:0] e;
        e = model.pop_front();
        chk(rdData == e, "R4 read order", int'(rdData), int'(e));
      end
    end
  end

  task automatic wrCycle(input bit en, input logic [8:0] d);
    @(negedge wrClk);
    wrEn1N = !en;
    wrData = d;
    if (en && wrEn2Ld && fullN) model.push_back(d);
  endtask

  task automatic rdCycle(input bit en);
    @(negedge rdClk);
    rdEn1N = !en;
    rdEn2N = !en;
  endtask

  task automatic settle();
    @(negedge wrClk); wrEn1N = 1;
    @(negedge rdClk); rdEn1N = 1; rdEn2N = 1;
    repeat (14) @(negedge rdClk);
  endtask

  task automatic writeN(input int n);
    for (int i = 0; i < n; i++) wrCycle(1, 9'($urandom));
    wrCycle(0, '0);
  endtask

  task automatic readN(input int n);
    for (int i = 0; i < n; i++) rdCycle(1);
    rdCycle(0);
  endtask

  task automatic checkFlags(input string tag);
    int n;
    n = model.size();
    chk(int'(emptyN) == ((n != 0) ? 1 : 0), {"R11 emptyN ", tag}, int'(emptyN), (n != 0) ? 1 : 0);
    chk(int'(fullN) == ((n != DEPTH) ? 1 : 0), {"R5 fullN ", tag}, int'(fullN), (n != DEPTH) ? 1 : 0);
    chk(int'(almostEmptyN) == expAeN(n), {"R7 almostEmptyN ", tag}, int'(almostEmptyN), expAeN(n));
    chk(int'(almostFullN) == expAfN(n), {"R8 almostFullN ", tag}, int'(almostFullN), expAfN(n));
  endtask

  task automatic doReset(input bit loadMode);
    @(negedge wrClk);
    rstN = 0; wrEn2Ld = !loadMode; wrEn1N = 1; rdEn1N = 1; rdEn2N = 1;
    model.delete(); aeExp = 7; afExp = 7; modeLoad = loadMode;
    repeat (4) @(negedge rdClk);
    chk(fullN && almostFullN && !emptyN && !almostEmptyN && !rdValid,
        "R1 flags during reset", {fullN, almostFullN, emptyN, almostEmptyN, rdValid}, 5'b11000);
    @(negedge wrClk); rstN = 1; wrEn2Ld = 1;
    repeat (3) @(negedge rdClk);
    chk(fullN && almostFullN && !emptyN && !almostEmptyN && !rdValid,
        "R1 flags after reset", {fullN, almostFullN, emptyN, almostEmptyN, rdValid}, 5'b11000);
  endtask

  initial begin
    repeat (200000) @(posedge wrClk);
    nFails++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h1d2c);
    nTests = 0; nFails = 0; rbMode = 0;
    rstN = 0; wrData = 0; wrEn1N = 1; wrEn2Ld = 1; rdEn1N = 1; rdEn2N = 1;

    // ---- dual-enable mode ----
    doReset(0);
    writeN(5);
    @(negedge wrClk) wrEn2Ld = 0;            // R2 second enable low blocks
    for (int i = 0; i < 3; i++) wrCycle(1, 9'h1AA);
    wrCycle(0, '0);
    @(negedge wrClk) wrEn2Ld = 1;
    settle();
    checkFlags("R2 five words after blocked writes");
    // R4: single read enable does not read
    @(negedge rdClk) begin rdEn1N = 0; rdEn2N = 1; end
    repeat (3) @(negedge rdClk) chk(!rdValid, "R4 one enable only", rdValid, 0);
    @(negedge rdClk) rdEn1N = 1;
    readN(5);
    settle();
    checkFlags("drained");
    // R6: read while empty
    rdCycle(1); rdCycle(1); rdCycle(0);
    @(negedge rdClk) chk(!rdValid && !emptyN, "R6 read while empty", rdValid, 0);

    // ---- thresholds and fill ----
    writeN(248); settle(); checkFlags("R8 free 8");
    writeN(1);   settle(); checkFlags("R8 free 7");
    for (int i = 0; i < 6; i++) wrCycle(1, 9'($urandom));
    @(posedge wrClk); #1 chk(fullN, "R11 fullN high at 255", fullN, 1);
    wrCycle(1, 9'($urandom));
    @(posedge wrClk); #1 chk(!fullN, "R11 fullN low after 256th", fullN, 0);
    for (int i = 0; i < 4; i++) wrCycle(1, 9'h0F0); // R5 dropped
    wrCycle(0, '0);
    settle(); checkFlags("R5 full after blocked writes");
    readN(248); settle(); checkFlags("R7 occupancy 8");
    readN(1);   settle(); checkFlags("R7 occupancy 7");
    for (int i = 0; i < 7; i++) rdCycle(1);
    @(posedge rdClk); #1 chk(!emptyN, "R11 emptyN low after last read", emptyN, 0);
    rdCycle(0);
    settle(); checkFlags("R6 drained after full");

    // ---- random traffic ----
    fork
      for (int i = 0; i < 900; i++) wrCycle(($urandom % 3) != 0, 9'($urandom));
      for (int i = 0; i < 600; i++) rdCycle(($urandom % 2) == 0);
    join
    settle();
    checkFlags("random");
    readN(model.size()); settle(); checkFlags("random drained");

    // ---- offset-load mode ----
    doReset(1);
    writeN(3);                                 // R3 data writes with load pin high
    @(negedge wrClk) wrEn2Ld = 0;
    wrCycle(1, 9'd40); wrCycle(1, 9'd30); wrCycle(1, 9'd20); wrCycle(0, '0);
    aeExp = 20; afExp = 30;                    // R9 wrap: third write lands in almost-empty
    settle();
    rbMode = 1;
    @(negedge rdClk) begin rdEn1N = 0; rdEn2N = 0; end
    @(negedge rdClk) chk(rdValid && rdData == 9'd20, "R10 readback 1", rdData, 20);
    @(negedge rdClk) chk(rdValid && rdData == 9'd30, "R10 readback 2", rdData, 30);
    @(negedge rdClk) begin
      chk(rdValid && rdData == 9'd20, "R10 readback 3", rdData, 20);
      rdEn1N = 1; rdEn2N = 1;
    end
    repeat (2) @(negedge rdClk);
    rbMode = 0;
    @(negedge wrClk) wrEn2Ld = 1;
    settle();
    checkFlags("R10 three words kept");
    writeN(22); settle(); checkFlags("R9 occupancy 25");
    readN(5);   settle(); checkFlags("R9 occupancy 20");
    writeN(206); settle(); checkFlags("R9 free 30");
    readN(1);   settle(); checkFlags("R9 free 31");
    readN(model.size()); settle(); checkFlags("R3 drained");

    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule